// File: doc/BRIEF.md
# SMRAM Region Decoder with Lockable Control

This host-bridge block owns an 8-bit control register for extended system-management memory. It classifies every CPU address that it is given against four windows: the legacy video-range hole, a high alias of that hole, a segment carved from the top of DRAM, and a high alias of that segment. For each address it decides whether the access goes to DRAM or to PCI, and it supplies the DRAM address to use. Both alias windows sit 256 MB above the DRAM they stand for, and they are folded back onto that DRAM.

Only code that runs in management mode, or runs while the open input is set, may reach the protected memory through the aliases. Any other access to an alias window is sent to PCI and raises a sticky violation flag. Software clears the flag by writing one to it.

A lock input freezes the window-shaping fields of the register. Routing and the remapped address are combinational from the inputs. The register and the flag change on the clock edge.

Top module: `smm_region_decoder`

## Requirements
- R1: After reset, reg_rd_data reads 0x38 and viol_flag is 0. Register bits 5, 4 and 3 always read as 1, whatever value is written.
- R2: While cfg_lock is 0, a write loads bit 7 (high-window select), bits 2:1 (segment size) and bit 0 (segment enable) from reg_wr_data. Writing 1 to bit 6 clears viol_flag, and writing 0 to bit 6 leaves viol_flag unchanged. Bit 6 reads back as viol_flag.
- R3: While cfg_lock is 1, writes leave bits 7, 2:1 and 0 unchanged. A write of 1 to bit 6 still clears viol_flag.
- R4: When smram_glb_en and bit 7 are both 1, an address in [0x000A0000, 0x00100000) routes to PCI (route_dram=0), and remap_addr equals acc_addr.
- R5: When smram_glb_en and bit 7 are both 1, an address in [0x100A0000, 0x10100000) routes to DRAM with remap_addr = acc_addr − 0x10000000, provided in_smm or smram_open is 1.
- R6: When smram_glb_en is 0 or bit 7 is 0, neither range of R4 or R5 gets special handling. Both follow R10.
- R7: Segment size is 128 KB shifted left by bits 2:1 (00=128 KB, 01=256 KB, 10=512 KB, 11=1 MB). When smram_glb_en and bit 0 are both 1, an address in [TOM − size, TOM) routes to PCI. When either is 0, that range follows R10.
- R8: When the segment is enabled, an address in [0x10000000 + TOM − size, 0x10000000 + TOM) routes to DRAM with remap_addr = acc_addr − 0x10000000, provided in_smm or smram_open is 1. The upper bound is excluded.
- R9: An alias-window access as in R5 or R8 with both in_smm and smram_open at 0 routes to PCI with remap_addr = acc_addr. If acc_valid is 1, viol_flag becomes 1 at the next clock edge.
- R10: Any other address routes to DRAM when it is below TOM and to PCI otherwise. In both cases remap_addr = acc_addr.
- R11: If a violation and a write of 1 to bit 6 fall in the same cycle, viol_flag ends up 1.
- R12: viol_flag is never set in a cycle where acc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |
| tom_addr | input | 32 | Top of DRAM, byte address aligned to 1 MB |
| smram_glb_en | input | 1 | Global enable for the management-memory windows |
| cfg_lock | input | 1 | Freezes bits 7, 2:1 and 0 |
| smram_open | input | 1 | Lets code outside management mode reach the alias windows |
| in_smm | input | 1 | CPU is in management mode |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | CPU byte address |
| route_dram | output | 1 | 1 = DRAM, 0 = PCI |
| remap_addr | output | 32 | Address to drive toward the chosen target |
| viol_flag | output | 1 | Sticky violation flag (register bit 6) |

## Verification
A wrong register bit shows up in two places: on reg_rd_data at the next sample, and as a changed routing decision for the window that the bit shapes. Routing is combinational, so a bad window bound or a bad remap offset shows on route_dram and remap_addr in the same cycle as the address. The tests therefore probe each bound from both sides. A flag fault appears exactly one edge after the access or the write that should have moved the flag, and it stays visible until the next clear.

// File: rtl/smm_dec_pkg.sv
package smm_dec_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned XW     = ADDR_W + 1;
    localparam int unsigned CTL_W  = 8;
    localparam int unsigned N_WIN  = 4;

    localparam logic [CTL_W-1:0] CTL_RST_VAL = 8'h38;

    localparam logic [XW-1:0] ALIAS_OFS = XW'(32'h1000_0000);
    localparam logic [XW-1:0] LEG_LO    = XW'(32'h000A_0000);
    localparam logic [XW-1:0] LEG_HI    = XW'(32'h0010_0000);
    localparam logic [XW-1:0] SEG_UNIT  = XW'(32'h0002_0000);

    // window indices, also the decode priority order
    localparam int unsigned W_HI_ALIAS  = 0;
    localparam int unsigned W_SEG_ALIAS = 1;
    localparam int unsigned W_LEGACY    = 2;
    localparam int unsigned W_SEG       = 3;

    typedef struct packed {
        logic       hi_sel;
        logic       viol;
        logic [2:0] fixed_ones;
        logic [1:0] seg_sz;
        logic       seg_en;
    } smm_ctl_t;

    typedef enum logic {
        ROUTE_PCI  = 1'b0,
        ROUTE_DRAM = 1'b1
    } route_e;

    typedef struct packed {
        route_e              route;
        logic [ADDR_W-1:0]   addr;
        logic                deny;
    } decode_t;

    function automatic logic [XW-1:0] seg_bytes(input logic [1:0] sz);
        return SEG_UNIT << sz;
    endfunction

endpackage

// File: rtl/smm_range_hit.sv
module smm_range_hit #(
    parameter int unsigned W = 33
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] addr,
    output logic         hit
);
    assign hit = (addr >= lo) && (addr < hi);
endmodule

// File: rtl/smm_ctl_reg.sv
module smm_ctl_reg
    import smm_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             lock,
    input  logic             viol_set,
    output smm_ctl_t         ctl_q
);
    logic       hi_sel_q;
    logic [1:0] seg_sz_q;
    logic       seg_en_q;
    logic       viol_q;
    logic       clr_req;

    assign clr_req = wr_en && wr_data[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_sel_q <= CTL_RST_VAL[7];
            seg_sz_q <= CTL_RST_VAL[2:1];
            seg_en_q <= CTL_RST_VAL[0];
            viol_q   <= CTL_RST_VAL[6];
        end else begin
            if (wr_en && !lock) begin
                hi_sel_q <= wr_data[7];
                seg_sz_q <= wr_data[2:1];
                seg_en_q <= wr_data[0];
            end
            // hardware set dominates a software clear
            viol_q <= viol_set | (viol_q & ~clr_req);
        end
    end

    always_comb begin
        ctl_q.hi_sel     = hi_sel_q;
        ctl_q.viol       = viol_q;
        ctl_q.fixed_ones = 3'b111;
        ctl_q.seg_sz     = seg_sz_q;
        ctl_q.seg_en     = seg_en_q;
    end
endmodule

// File: rtl/smm_addr_decode.sv
module smm_addr_decode
    import smm_dec_pkg::*;
(
    input  smm_ctl_t          ctl,
    input  logic [ADDR_W-1:0] tom,
    input  logic              glb_en,
    input  logic              in_smm,
    input  logic              open_en,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output decode_t           res,
    output logic              viol_hit
);
    logic [XW-1:0]    ax, tom_x, seg_lo;
    logic [XW-1:0]    win_lo [N_WIN];
    logic [XW-1:0]    win_hi [N_WIN];
    logic [N_WIN-1:0] hit;
    logic             hi_on, seg_on, allowed;

    assign ax      = XW'(addr);
    assign tom_x   = XW'(tom);
    assign seg_lo  = tom_x - seg_bytes(ctl.seg_sz);
    assign hi_on   = glb_en && ctl.hi_sel;
    assign seg_on  = glb_en && ctl.seg_en;
    assign allowed = in_smm || open_en;

    always_comb begin
        win_lo[W_HI_ALIAS]  = LEG_LO + ALIAS_OFS;
        win_hi[W_HI_ALIAS]  = LEG_HI + ALIAS_OFS;
        win_lo[W_SEG_ALIAS] = seg_lo + ALIAS_OFS;
        win_hi[W_SEG_ALIAS] = tom_x + ALIAS_OFS;
        win_lo[W_LEGACY]    = LEG_LO;
        win_hi[W_LEGACY]    = LEG_HI;
        win_lo[W_SEG]       = seg_lo;
        win_hi[W_SEG]       = tom_x;
    end

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        smm_range_hit #(.W(XW)) u_hit (
            .lo   (win_lo[i]),
            .hi   (win_hi[i]),
            .addr (ax),
            .hit  (hit[i])
        );
    end

    always_comb begin
        res.route = ROUTE_PCI;
        res.addr  = addr;
        res.deny  = 1'b0;
        if ((hi_on && hit[W_HI_ALIAS]) || (seg_on && hit[W_SEG_ALIAS])) begin
            if (allowed) begin
                res.route = ROUTE_DRAM;
                res.addr  = ADDR_W'(ax - ALIAS_OFS);
            end else begin
                res.deny  = 1'b1;
            end
        end else if (hi_on && hit[W_LEGACY]) begin
            res.route = ROUTE_PCI;
        end else if (seg_on && hit[W_SEG]) begin
            res.route = ROUTE_PCI;
        end else if (ax < tom_x) begin
            res.route = ROUTE_DRAM;
        end
    end

    assign viol_hit = valid && res.deny;
endmodule

// File: rtl/smm_region_decoder.sv
module smm_region_decoder
    import smm_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [CTL_W-1:0]  reg_wr_data,
    output logic [CTL_W-1:0]  reg_rd_data,
    input  logic [ADDR_W-1:0] tom_addr,
    input  logic              smram_glb_en,
    input  logic              cfg_lock,
    input  logic              smram_open,
    input  logic              in_smm,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              route_dram,
    output logic [ADDR_W-1:0] remap_addr,
    output logic              viol_flag
);
    smm_ctl_t ctl;
    decode_t  dec;
    logic     viol_hit;

    smm_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .lock     (cfg_lock),
        .viol_set (viol_hit),
        .ctl_q    (ctl)
    );

    smm_addr_decode u_dec (
        .ctl      (ctl),
        .tom      (tom_addr),
        .glb_en   (smram_glb_en),
        .in_smm   (in_smm),
        .open_en  (smram_open),
        .valid    (acc_valid),
        .addr     (acc_addr),
        .res      (dec),
        .viol_hit (viol_hit)
    );

    assign reg_rd_data = ctl;
    assign route_dram  = (dec.route == ROUTE_DRAM);
    assign remap_addr  = dec.addr;
    assign viol_flag   = ctl.viol;
endmodule

// File: rtl/smm_dec_checker.sv
module smm_dec_checker
    import smm_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [CTL_W-1:0]  reg_wr_data,
    input logic [CTL_W-1:0]  reg_rd_data,
    input logic              smram_glb_en,
    input logic              cfg_lock,
    input logic              smram_open,
    input logic              in_smm,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              route_dram,
    input logic [ADDR_W-1:0] remap_addr,
    input logic              viol_flag
);
    logic hi_on, in_leg, in_hi_alias, ok_mode;

    assign hi_on       = smram_glb_en && reg_rd_data[7];
    assign in_leg      = (acc_addr >= 32'h000A_0000) && (acc_addr < 32'h0010_0000);
    assign in_hi_alias = (acc_addr >= 32'h100A_0000) && (acc_addr < 32'h1010_0000);
    assign ok_mode     = in_smm || smram_open;

    p_fixed_ones_r1: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[5:3] == 3'b111);

    p_w0_keeps_flag_r2: assert property (@(posedge clk) disable iff (rst)
        viol_flag && !(reg_wr_en && reg_wr_data[6]) |=> viol_flag);

    p_w1_clears_r2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && reg_wr_data[6] && !acc_valid |=> !viol_flag);

    p_lock_holds_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_lock |=> ($stable(reg_rd_data[7]) && $stable(reg_rd_data[2:0])));

    p_legacy_pci_r4: assert property (@(posedge clk) disable iff (rst)
        hi_on && in_leg |-> !route_dram && remap_addr == acc_addr);

    p_hi_remap_r5: assert property (@(posedge clk) disable iff (rst)
        hi_on && in_hi_alias && ok_mode |->
            route_dram && remap_addr == (acc_addr - 32'h1000_0000));

    p_deny_sets_r9_r11: assert property (@(posedge clk) disable iff (rst)
        hi_on && in_hi_alias && !ok_mode && acc_valid |-> !route_dram ##1 viol_flag);

    p_idle_no_set_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid && !viol_flag |=> !viol_flag);
endmodule

bind smm_region_decoder smm_dec_checker u_chk (.*);

// File: tb/smm_region_decoder_tb.sv
module smm_region_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TOM = 32'h0400_0000;

    typedef struct packed {
        logic [7:0]  ctl;
        logic        glb;
        logic        smm;
        logic        opn;
        logic [31:0] addr;
        logic        exp_dram;
        logic [31:0] exp_addr;
    } vec_t;

    localparam int NV = 24;
    // segment base with TOM = 64 MB: 128K 0x03FE0000, 256K 0x03FC0000, 512K 0x03F80000, 1M 0x03F00000
    localparam vec_t VECS [0:NV-1] = '{
        '{8'h81, 1'b1, 1'b1, 1'b0, 32'h000B_8000, 1'b0, 32'h000B_8000}, // R4
        '{8'h81, 1'b1, 1'b1, 1'b0, 32'h000A_0000, 1'b0, 32'h000A_0000}, // R4 low edge
        '{8'h81, 1'b1, 1'b1, 1'b0, 32'h100A_0000, 1'b1, 32'h000A_0000}, // R5
        '{8'h81, 1'b1, 1'b1, 1'b0, 32'h100F_FFFF, 1'b1, 32'h000F_FFFF}, // R5 top
        '{8'h81, 1'b1, 1'b1, 1'b0, 32'h1010_0000, 1'b0, 32'h1010_0000}, // R5 excluded bound
        '{8'h01, 1'b1, 1'b1, 1'b0, 32'h000B_8000, 1'b1, 32'h000B_8000}, // R6 bit7=0
        '{8'h01, 1'b1, 1'b1, 1'b0, 32'h100B_0000, 1'b0, 32'h100B_0000}, // R6
        '{8'h81, 1'b0, 1'b1, 1'b0, 32'h000A_0000, 1'b1, 32'h000A_0000}, // R6 glb=0
        '{8'h81, 1'b0, 1'b1, 1'b0, 32'h100A_0000, 1'b0, 32'h100A_0000}, // R6 glb=0
        '{8'h01, 1'b1, 1'b1, 1'b0, 32'h03FE_0000, 1'b0, 32'h03FE_0000}, // R7 128K
        '{8'h01, 1'b1, 1'b1, 1'b0, 32'h03FD_FFFF, 1'b1, 32'h03FD_FFFF}, // R7
        '{8'h03, 1'b1, 1'b1, 1'b0, 32'h03FC_0000, 1'b0, 32'h03FC_0000}, // R7 256K
        '{8'h03, 1'b1, 1'b1, 1'b0, 32'h03FB_FFFF, 1'b1, 32'h03FB_FFFF}, // R7
        '{8'h05, 1'b1, 1'b1, 1'b0, 32'h03F8_0000, 1'b0, 32'h03F8_0000}, // R7 512K
        '{8'h05, 1'b1, 1'b1, 1'b0, 32'h03F7_FFFF, 1'b1, 32'h03F7_FFFF}, // R7
        '{8'h07, 1'b1, 1'b1, 1'b0, 32'h03F0_0000, 1'b0, 32'h03F0_0000}, // R7 1M
        '{8'h00, 1'b1, 1'b1, 1'b0, 32'h03FE_0000, 1'b1, 32'h03FE_0000}, // R7 disabled
        '{8'h01, 1'b1, 1'b1, 1'b0, 32'h13FE_0000, 1'b1, 32'h03FE_0000}, // R8
        '{8'h01, 1'b1, 1'b1, 1'b0, 32'h13FF_FFFF, 1'b1, 32'h03FF_FFFF}, // R8
        '{8'h01, 1'b1, 1'b1, 1'b0, 32'h1400_0000, 1'b0, 32'h1400_0000}, // R8 excluded bound
        '{8'h01, 1'b1, 1'b0, 1'b1, 32'h13FE_0000, 1'b1, 32'h03FE_0000}, // R8 via open
        '{8'h01, 1'b1, 1'b0, 1'b0, 32'h13FE_0000, 1'b0, 32'h13FE_0000}, // R9
        '{8'h80, 1'b1, 1'b0, 1'b0, 32'h100A_0000, 1'b0, 32'h100A_0000}, // R9
        '{8'h00, 1'b1, 1'b1, 1'b0, 32'h0400_0000, 1'b0, 32'h0400_0000}  // R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_data;
    logic [7:0]  reg_rd_data;
    logic [31:0] tom_addr;
    logic        smram_glb_en, cfg_lock, smram_open, in_smm, acc_valid;
    logic [31:0] acc_addr;
    logic        route_dram;
    logic [31:0] remap_addr;
    logic        viol_flag;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smm_region_decoder u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .tom_addr(tom_addr), .smram_glb_en(smram_glb_en),
        .cfg_lock(cfg_lock), .smram_open(smram_open), .in_smm(in_smm),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .route_dram(route_dram),
        .remap_addr(remap_addr), .viol_flag(viol_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge capture, return at the next falling edge
    task automatic wr_ctl(input logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = 8'h00;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_data = 8'h00; tom_addr = TOM;
        smram_glb_en = 1'b1; cfg_lock = 1'b0; smram_open = 1'b0; in_smm = 1'b1;
        acc_valid = 1'b0; acc_addr = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset value", {24'h0, reg_rd_data}, 32'h38);
        check("R1 reset flag", {31'h0, viol_flag}, 32'h0);

        // R2 and R1: read-back of writable bits and the forced ones
        wr_ctl(8'hFF); #1;
        check("R2/R1 write ff", {24'h0, reg_rd_data}, 32'hBF);
        wr_ctl(8'h00); #1;
        check("R1 fixed ones after write 00", {24'h0, reg_rd_data}, 32'h38);

        // table walk: routing and remap
        for (int i = 0; i < NV; i++) begin
            wr_ctl(VECS[i].ctl);
            smram_glb_en = VECS[i].glb;
            in_smm = VECS[i].smm;
            smram_open = VECS[i].opn;
            acc_addr = VECS[i].addr;
            #1;
            check($sformatf("vec%0d route", i), {31'h0, route_dram}, {31'h0, VECS[i].exp_dram});
            check($sformatf("vec%0d remap", i), remap_addr, VECS[i].exp_addr);
        end
        acc_addr = 32'h03FF_FFFF; wr_ctl(8'h00); #1;
        check("R10 below TOM", {31'h0, route_dram}, 32'h1);
        acc_addr = 32'h0; #1;
        check("R10 zero", {31'h0, route_dram}, 32'h1);

        // R12: denied address without acc_valid leaves the flag clear
        smram_glb_en = 1'b1; in_smm = 1'b0; smram_open = 1'b0;
        wr_ctl(8'h81);
        acc_addr = 32'h100A_0000; acc_valid = 1'b0;
        tick(); #1;
        check("R12 no access no flag", {31'h0, viol_flag}, 32'h0);

        // R9: a real denied access sets the flag one edge later
        acc_valid = 1'b1; #1;
        check("R9 flag not yet set", {31'h0, viol_flag}, 32'h0);
        tick(); acc_valid = 1'b0; #1;
        check("R9 flag set", {31'h0, viol_flag}, 32'h1);

        // R12: a permitted alias access sets nothing; flag cleared first
        wr_ctl(8'hC1); #1;
        check("R2 write-one clears", {31'h0, viol_flag}, 32'h0);
        in_smm = 1'b1; acc_valid = 1'b1; tick(); acc_valid = 1'b0; #1;
        check("R12 permitted access no flag", {31'h0, viol_flag}, 32'h0);
        in_smm = 1'b0;

        // R2: writing 0 to bit 6 keeps a set flag
        acc_valid = 1'b1; tick(); acc_valid = 1'b0;
        wr_ctl(8'h81); #1;
        check("R2 write-zero keeps flag", {31'h0, viol_flag}, 32'h1);

        // R11: set and clear in the same cycle
        acc_valid = 1'b1; wr_ctl(8'hC1); acc_valid = 1'b0; #1;
        check("R11 set wins", {31'h0, viol_flag}, 32'h1);
        wr_ctl(8'hC1); #1;
        check("R2 clear after R11", {31'h0, viol_flag}, 32'h0);

        // R3: lock freezes bits 7, 2:1, 0
        cfg_lock = 1'b1;
        wr_ctl(8'h06); #1;
        check("R3 locked write ignored", {24'h0, reg_rd_data}, 32'hB9);
        acc_addr = 32'h000B_8000; #1;
        check("R3 decode unchanged", {31'h0, route_dram}, 32'h0);
        acc_addr = 32'h100A_0000; acc_valid = 1'b1; tick(); acc_valid = 1'b0;
        wr_ctl(8'h40); #1;
        check("R3 clear works while locked", {24'h0, reg_rd_data}, 32'hB9);
        cfg_lock = 1'b0;
        wr_ctl(8'h06); #1;
        check("R2 unlocked write takes", {24'h0, reg_rd_data}, 32'h3E);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule